// File: doc/BRIEF.md
# Bounded Push-Down Stack Controller

This block executes one single-word push or pull against a stack that lives in a word-addressed memory. The caller supplies the operation, a register word and a 64-bit pointer doubleword. The doubleword packs five things: a top-of-stack address, a count of free slots, a count of occupied slots, and one trap-inhibit flag for each count. The block checks both counts against their limits and then does one of three things:

- it performs the memory access and returns the updated doubleword;
- it requests a limit trap;
- when every failing limit is inhibited, it aborts and leaves the doubleword unchanged.

Every operation takes the same number of cycles, whichever path it follows. A single-cycle completion pulse presents the following, all at once:

- the new doubleword;
- a 4-bit condition code;
- the pulled word;
- the trap and abort flags.

The surrounding processor holds the doubleword in its own storage. It writes back whatever the block returns. On a trap it vectors to the reported location.

Top module: `pushdown_stack_ctl`

## Requirements
- R1: Pointer layout, as `ptr_i[63:0]`:
  - `[14:0]` word count;
  - `[15]` word-limit inhibit;
  - `[30:16]` space count;
  - `[31]` space-limit inhibit;
  - `[48:32]` top-of-stack address;
  - `[63:49]` carried through to `ptr_o` unchanged on every completion.

  `cmd_pull_i` = 0 selects push and 1 selects pull. The condition code is `cc_o[3]`=CC1, `cc_o[2]`=CC2, `cc_o[1]`=CC3, `cc_o[0]`=CC4.
- R2: A push that passes its checks writes `reg_data_i` to address top+1 with exactly one write strobe. It returns top+1, space−1 and word+1.
- R3: A pull that passes its checks reads the word at the current top with exactly one read strobe. The memory returns data one cycle after the strobe. The pull delivers that word on `pull_data_o` and returns top−1, space+1 and word−1.
- R4: On a completed operation, CC1 = CC3 = 0. CC2 = 1 exactly when the resulting space count is zero. CC4 = 1 exactly when the resulting word count is zero.
- R5: The limit checks are:
  - a push fails on the space limit when space = 0, and on the word limit when word = 2^15−1;
  - a pull fails on the word limit when word = 0, and on the space limit when space = 2^15−1.
- R6: If any failing limit has its inhibit flag at 0, the completion carries `trap_o` = 1 and `trap_vec_o` = 0x42. In that case cc = 0000, the pointer is unchanged, `abort_o` = 0 and there is no memory strobe.
- R7: If limits fail and all of them are inhibited, the completion carries `abort_o` = 1 and `trap_o` = 0. The pointer is unchanged and there is no memory strobe. The condition code is:
  - CC1 = the word limit failed;
  - CC3 = the space limit failed;
  - CC2 = the unchanged space count is zero;
  - CC4 = the unchanged word count is zero.
- R8: A command is accepted on a clock edge where `cmd_valid_i` = 1 and `busy_o` = 0. `done_o` is high for exactly one cycle, four cycles after acceptance. `busy_o` stays high from acceptance through completion. Commands presented while busy are ignored.
- R9: During reset and after it, until a command arrives, `done_o`, `busy_o`, `trap_o`, `abort_o`, `mem_we_o` and `mem_re_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_pull_i | input | 1 | 0 push, 1 pull |
| reg_data_i | input | 32 | Register word to push |
| ptr_i | input | 64 | Stack pointer doubleword |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| ptr_o | output | 64 | Updated pointer doubleword |
| cc_o | output | 4 | Condition code CC1..CC4 |
| pull_data_o | output | 32 | Word read by the last successful pull |
| trap_o | output | 1 | Limit trap request (with done) |
| trap_vec_o | output | 8 | Trap vector location, valid with trap_o |
| abort_o | output | 1 | Inhibited limit abort (with done) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 17 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the strobe |

## Verification
The assertions assume the memory answers a read strobe with valid data in the following cycle. They also assume `ptr_i` and `reg_data_i` are stable at the accepting edge. The bench meets both assumptions with a registered memory model, and it drives every input on the falling clock edge. The stimulus never relies on the top-of-stack address wrapping. Commands presented while the block is busy appear only in the dedicated scenario, and the bench withdraws them before the block returns to idle.

// File: rtl/pdstk_pkg.sv
package pdstk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHECK  = 3'd1,
    ST_MEM    = 3'd2,
    ST_SETTLE = 3'd3,
    ST_DONE   = 3'd4
  } pd_state_e;
endpackage

// File: rtl/pdstk_limit_chk.sv
module pdstk_limit_chk #(
  parameter int CNT_W = 15
) (
  input  logic             is_pull,
  input  logic [CNT_W-1:0] space_cnt,
  input  logic [CNT_W-1:0] word_cnt,
  input  logic             space_inh,
  input  logic             word_inh,
  output logic             space_flt,
  output logic             word_flt,
  output logic             trap_req,
  output logic             abort_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  always_comb begin
    if (is_pull) begin
      space_flt = (space_cnt == CNT_MAX);
      word_flt  = (word_cnt == CNT_ZERO);
    end else begin
      space_flt = (space_cnt == CNT_ZERO);
      word_flt  = (word_cnt == CNT_MAX);
    end
    trap_req  = (space_flt && !space_inh) || (word_flt && !word_inh);
    abort_req = (space_flt || word_flt) && !trap_req;
  end
endmodule

// File: rtl/pdstk_ptr_update.sv
module pdstk_ptr_update #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 15
) (
  input  logic              is_pull,
  input  logic [ADDR_W-1:0] top_addr,
  input  logic [CNT_W-1:0]  space_cnt,
  input  logic [CNT_W-1:0]  word_cnt,
  output logic [ADDR_W-1:0] top_nx,
  output logic [CNT_W-1:0]  space_nx,
  output logic [CNT_W-1:0]  word_nx,
  output logic              space_zero_nx,
  output logic              word_zero_nx
);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

  always_comb begin
    if (is_pull) begin
      top_nx   = top_addr - A_ONE;
      space_nx = space_cnt + C_ONE;
      word_nx  = word_cnt - C_ONE;
    end else begin
      top_nx   = top_addr + A_ONE;
      space_nx = space_cnt - C_ONE;
      word_nx  = word_cnt + C_ONE;
    end
    space_zero_nx = (space_nx == '0);
    word_zero_nx  = (word_nx == '0);
  end
endmodule

// File: rtl/pdstk_seq.sv
module pdstk_seq
  import pdstk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  output pd_state_e state_o
);
  pd_state_e st_q, st_d;

  always_comb begin
    unique case (st_q)
      ST_IDLE:   st_d = start ? ST_CHECK : ST_IDLE;
      ST_CHECK:  st_d = ST_MEM;
      ST_MEM:    st_d = ST_SETTLE;
      ST_SETTLE: st_d = ST_DONE;
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // R8
  done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> (st_q == ST_IDLE));

  // R8
  check_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start) |=> (st_q == ST_CHECK));
endmodule

// File: rtl/pushdown_stack_ctl.sv
module pushdown_stack_ctl
  import pdstk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 15,
  parameter int PASS_W = 15,
  parameter logic [7:0] TRAP_VEC = 8'h42,
  localparam int PTR_W = PASS_W + ADDR_W + 2 * CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic              cmd_pull_i,
  input  logic [DATA_W-1:0] reg_data_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [3:0]        cc_o,
  output logic [DATA_W-1:0] pull_data_o,
  output logic              trap_o,
  output logic [7:0]        trap_vec_o,
  output logic              abort_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int WORD_LSB  = 0;
  localparam int WINH_BIT  = CNT_W;
  localparam int SPACE_LSB = CNT_W + 1;
  localparam int SINH_BIT  = 2 * CNT_W + 1;
  localparam int ADDR_LSB  = 2 * CNT_W + 2;
  localparam int PASS_LSB  = ADDR_LSB + ADDR_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  pd_state_e st;
  logic      accept;
  assign accept = cmd_valid_i && (st == ST_IDLE);

  pdstk_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start   (cmd_valid_i),
    .state_o (st)
  );

  // command capture
  logic              pull_q;
  logic [DATA_W-1:0] data_q;
  logic [PTR_W-1:0]  ptr_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pull_q <= 1'b0;
      data_q <= '0;
      ptr_q  <= '0;
    end else if (accept) begin
      pull_q <= cmd_pull_i;
      data_q <= reg_data_i;
      ptr_q  <= ptr_i;
    end
  end

  logic [ADDR_W-1:0] top_addr;
  logic [CNT_W-1:0]  space_cnt, word_cnt;
  logic              space_inh, word_inh;
  logic [PASS_W-1:0] pass_bits;
  assign word_cnt  = ptr_q[WORD_LSB +: CNT_W];
  assign word_inh  = ptr_q[WINH_BIT];
  assign space_cnt = ptr_q[SPACE_LSB +: CNT_W];
  assign space_inh = ptr_q[SINH_BIT];
  assign top_addr  = ptr_q[ADDR_LSB +: ADDR_W];
  assign pass_bits = ptr_q[PASS_LSB +: PASS_W];

  logic space_flt, word_flt, trap_req, abort_req;
  pdstk_limit_chk #(.CNT_W(CNT_W)) u_lim (
    .is_pull   (pull_q),
    .space_cnt (space_cnt),
    .word_cnt  (word_cnt),
    .space_inh (space_inh),
    .word_inh  (word_inh),
    .space_flt (space_flt),
    .word_flt  (word_flt),
    .trap_req  (trap_req),
    .abort_req (abort_req)
  );

  logic [ADDR_W-1:0] top_nx;
  logic [CNT_W-1:0]  space_nx, word_nx;
  logic              space_zero_nx, word_zero_nx;
  pdstk_ptr_update #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_upd (
    .is_pull       (pull_q),
    .top_addr      (top_addr),
    .space_cnt     (space_cnt),
    .word_cnt      (word_cnt),
    .top_nx        (top_nx),
    .space_nx      (space_nx),
    .word_nx       (word_nx),
    .space_zero_nx (space_zero_nx),
    .word_zero_nx  (word_zero_nx)
  );

  // decision registered in CHECK
  logic trap_q, abort_q, sflt_q, wflt_q, ok_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      trap_q  <= 1'b0;
      abort_q <= 1'b0;
      sflt_q  <= 1'b0;
      wflt_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else if (st == ST_CHECK) begin
      trap_q  <= trap_req;
      abort_q <= abort_req;
      sflt_q  <= space_flt;
      wflt_q  <= word_flt;
      ok_q    <= !(space_flt || word_flt);
    end
  end

  // memory port
  assign mem_we_o    = (st == ST_MEM) && ok_q && !pull_q;
  assign mem_re_o    = (st == ST_MEM) && ok_q && pull_q;
  assign mem_addr_o  = pull_q ? top_addr : top_nx;
  assign mem_wdata_o = data_q;

  // result assembly
  logic [PTR_W-1:0]  ptr_d;
  logic [3:0]        cc_d;
  always_comb begin
    if (ok_q) begin
      ptr_d = {pass_bits, top_nx, space_inh, space_nx, word_inh, word_nx};
      cc_d  = {1'b0, space_zero_nx, 1'b0, word_zero_nx};
    end else if (abort_q) begin
      ptr_d = ptr_q;
      cc_d  = {wflt_q, (space_cnt == '0), sflt_q, (word_cnt == '0)};
    end else begin
      ptr_d = ptr_q;
      cc_d  = 4'b0000;
    end
  end

  logic [PTR_W-1:0]  ptr_res_q;
  logic [3:0]        cc_res_q;
  logic [DATA_W-1:0] rd_res_q;
  logic              trap_res_q, abort_res_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ptr_res_q   <= '0;
      cc_res_q    <= '0;
      trap_res_q  <= 1'b0;
      abort_res_q <= 1'b0;
    end else if (st == ST_SETTLE) begin
      ptr_res_q   <= ptr_d;
      cc_res_q    <= cc_d;
      trap_res_q  <= trap_q;
      abort_res_q <= abort_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)                              rd_res_q <= '0;
    else if (st == ST_SETTLE && ok_q && pull_q) rd_res_q <= mem_rdata_i;
  end

  assign busy_o      = (st != ST_IDLE);
  assign done_o      = (st == ST_DONE);
  assign ptr_o       = ptr_res_q;
  assign cc_o        = cc_res_q;
  assign pull_data_o = rd_res_q;
  assign trap_o      = done_o && trap_res_q;
  assign abort_o     = done_o && abort_res_q;
  assign trap_vec_o  = trap_o ? TRAP_VEC : 8'h00;

  // R2 R3
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({mem_we_o, mem_re_o}));

  // R2
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_we_o |-> (mem_addr_o == top_addr + ADDR_W'(1)));

  // R8
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |-> $past(accept, 4));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |=> !done_o);

  // R6
  trap_keep_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    trap_o |-> (ptr_o == ptr_q && cc_o == 4'b0000 && !abort_o));

  // R7
  abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    abort_o |-> (ptr_o == ptr_q && (cc_o[3] || cc_o[1])));

  // R4
  cc_ok_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done_o && !trap_o && !abort_o) |->
      (!cc_o[3] && !cc_o[1] &&
       cc_o[2] == (ptr_o[SPACE_LSB +: CNT_W] == '0) &&
       cc_o[0] == (ptr_o[WORD_LSB +: CNT_W] == '0)));

  // R1
  pass_keep_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |-> (ptr_o[PASS_LSB +: PASS_W] == ptr_q[PASS_LSB +: PASS_W]));
endmodule

// File: tb/pushdown_stack_ctl_tb_top.sv
module pushdown_stack_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid_i, cmd_pull_i;
  logic [31:0] reg_data_i;
  logic [63:0] ptr_i;
  logic        busy_o, done_o, trap_o, abort_o, mem_we_o, mem_re_o;
  logic [63:0] ptr_o;
  logic [3:0]  cc_o;
  logic [31:0] pull_data_o, mem_wdata_o;
  logic [31:0] mem_rdata_i;
  logic [7:0]  trap_vec_o;
  logic [16:0] mem_addr_o;

  int n_tests = 0;
  int n_fail  = 0;
  int wr_cnt  = 0;
  int rd_cnt  = 0;
  bit finished = 0;
  logic [31:0] mem_model [256];

  always #10 clk = ~clk;

  pushdown_stack_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_pull_i(cmd_pull_i),
    .reg_data_i(reg_data_i), .ptr_i(ptr_i), .busy_o(busy_o), .done_o(done_o),
    .ptr_o(ptr_o), .cc_o(cc_o), .pull_data_o(pull_data_o), .trap_o(trap_o),
    .trap_vec_o(trap_vec_o), .abort_o(abort_o), .mem_we_o(mem_we_o),
    .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  always @(posedge clk) begin
    if (mem_we_o) begin
      mem_model[mem_addr_o[7:0]] <= mem_wdata_o;
      wr_cnt = wr_cnt + 1;
    end
    if (mem_re_o) begin
      mem_rdata_i <= mem_model[mem_addr_o[7:0]];
      rd_cnt = rd_cnt + 1;
    end
  end

  function automatic logic [63:0] mk_ptr(input logic [14:0] pass, input logic [16:0] addr,
                                         input logic ts, input logic [14:0] sp,
                                         input logic tw, input logic [14:0] wd);
    return {pass, addr, ts, sp, tw, wd};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic pull, input logic [31:0] d, input logic [63:0] p,
                        input bit intrude, output int lat);
    @(negedge clk);
    cmd_pull_i = pull; reg_data_i = d; ptr_i = p; cmd_valid_i = 1'b1;
    wr_cnt = 0; rd_cnt = 0;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 20) begin
      @(negedge clk);
      lat++;
      if (intrude && lat == 2) begin
        cmd_pull_i = ~pull; ptr_i = ~p; reg_data_i = ~d; cmd_valid_i = 1'b1;
      end
      if (intrude && lat == 3) cmd_valid_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R9", "done in reset", {63'd0, done_o}, 64'd0);
    chk("R9", "busy in reset", {63'd0, busy_o}, 64'd0);
    chk("R9", "mem strobes in reset", {62'd0, mem_we_o, mem_re_o}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "idle after reset", {60'd0, done_o, busy_o, trap_o, abort_o}, 64'd0);
  endtask

  task automatic t_push_ok();
    int lat;
    run_op(1'b0, 32'hDEAD_BEEF, mk_ptr(15'h1ABC, 17'h10, 1'b0, 15'd5, 1'b0, 15'd3), 0, lat);
    chk("R8", "push latency", lat, 4);
    chk("R2", "push ptr", ptr_o, mk_ptr(15'h1ABC, 17'h11, 1'b0, 15'd4, 1'b0, 15'd4));
    chk("R1", "pass bits", ptr_o[63:49], 15'h1ABC);
    chk("R4", "push cc", cc_o, 4'b0000);
    chk("R2", "push writes", wr_cnt, 1);
    chk("R2", "push reads", rd_cnt, 0);
    chk("R2", "memory word", mem_model[8'h11], 32'hDEAD_BEEF);
    chk("R6", "no trap/abort", {trap_o, abort_o}, 2'b00);
    @(negedge clk);
    chk("R8", "done one cycle", {busy_o, done_o}, 2'b00);
  endtask

  task automatic t_pull_ok();
    int lat;
    run_op(1'b1, 32'h0, mk_ptr(15'h1ABC, 17'h11, 1'b0, 15'd4, 1'b0, 15'd4), 0, lat);
    chk("R8", "pull latency", lat, 4);
    chk("R3", "pull data", pull_data_o, 32'hDEAD_BEEF);
    chk("R3", "pull ptr", ptr_o, mk_ptr(15'h1ABC, 17'h10, 1'b0, 15'd5, 1'b0, 15'd3));
    chk("R3", "pull reads", rd_cnt, 1);
    chk("R3", "pull writes", wr_cnt, 0);
    chk("R4", "pull cc", cc_o, 4'b0000);
  endtask

  task automatic t_push_to_full();
    int lat;
    run_op(1'b0, 32'h1234_5678, mk_ptr(15'h0, 17'h40, 1'b1, 15'd1, 1'b1, 15'd7), 0, lat);
    chk("R4", "full cc", cc_o, 4'b0100);
    chk("R2", "full ptr", ptr_o, mk_ptr(15'h0, 17'h41, 1'b1, 15'd0, 1'b1, 15'd8));
    chk("R2", "memory word", mem_model[8'h41], 32'h1234_5678);
  endtask

  task automatic t_pull_to_empty();
    int lat;
    mem_model[8'h20] = 32'hCAFE_0001;
    run_op(1'b1, 32'h0, mk_ptr(15'h7FFF, 17'h20, 1'b0, 15'd2, 1'b0, 15'd1), 0, lat);
    chk("R4", "empty cc", cc_o, 4'b0001);
    chk("R3", "empty ptr", ptr_o, mk_ptr(15'h7FFF, 17'h1F, 1'b0, 15'd3, 1'b0, 15'd0));
    chk("R3", "empty data", pull_data_o, 32'hCAFE_0001);
  endtask

  task automatic t_push_trap();
    int lat;
    logic [63:0] p;
    p = mk_ptr(15'h5, 17'h30, 1'b0, 15'd0, 1'b0, 15'd9);
    run_op(1'b0, 32'hAAAA_AAAA, p, 0, lat);
    chk("R8", "trap latency", lat, 4);
    chk("R6", "trap flags", {trap_o, abort_o}, 2'b10);
    chk("R6", "trap vector", trap_vec_o, 8'h42);
    chk("R6", "trap ptr", ptr_o, p);
    chk("R6", "trap cc", cc_o, 4'b0000);
    chk("R6", "trap strobes", wr_cnt + rd_cnt, 0);
  endtask

  task automatic t_push_mixed_trap();
    int lat;
    logic [63:0] p;
    p = mk_ptr(15'h5, 17'h30, 1'b1, 15'd0, 1'b0, 15'h7FFF);
    run_op(1'b0, 32'h5555_5555, p, 0, lat);
    chk("R6", "mixed inhibit traps", {trap_o, abort_o}, 2'b10);
    chk("R5", "mixed ptr", ptr_o, p);
  endtask

  task automatic t_push_abort_both();
    int lat;
    logic [63:0] p;
    p = mk_ptr(15'h3, 17'h50, 1'b1, 15'd0, 1'b1, 15'h7FFF);
    run_op(1'b0, 32'hBBBB_BBBB, p, 0, lat);
    chk("R7", "abort flags", {trap_o, abort_o}, 2'b01);
    chk("R7", "abort both cc", cc_o, 4'b1110);
    chk("R7", "abort ptr", ptr_o, p);
    chk("R7", "abort strobes", wr_cnt + rd_cnt, 0);
    chk("R5", "abort latency", lat, 4);
  endtask

  task automatic t_pull_abort_word();
    int lat;
    logic [63:0] p;
    p = mk_ptr(15'h0, 17'h60, 1'b0, 15'd9, 1'b1, 15'd0);
    run_op(1'b1, 32'h0, p, 0, lat);
    chk("R7", "pull abort flags", {trap_o, abort_o}, 2'b01);
    chk("R7", "pull abort cc", cc_o, 4'b1001);
    chk("R7", "pull abort ptr", ptr_o, p);
    chk("R5", "pull abort reads", rd_cnt, 0);
  endtask

  task automatic t_pull_trap_space();
    int lat;
    logic [63:0] p;
    p = mk_ptr(15'h0, 17'h60, 1'b0, 15'h7FFF, 1'b0, 15'd4);
    run_op(1'b1, 32'h0, p, 0, lat);
    chk("R5", "pull space limit traps", {trap_o, abort_o}, 2'b10);
    chk("R6", "pull trap ptr", ptr_o, p);
  endtask

  task automatic t_busy_ignore();
    int lat;
    int extra;
    run_op(1'b0, 32'h0F0F_0F0F, mk_ptr(15'h0, 17'h70, 1'b0, 15'd6, 1'b0, 15'd2), 1, lat);
    chk("R8", "busy latency", lat, 4);
    chk("R8", "first op result", ptr_o, mk_ptr(15'h0, 17'h71, 1'b0, 15'd5, 1'b0, 15'd3));
    extra = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done_o || busy_o) extra++;
    end
    chk("R8", "ignored command", extra, 0);
    chk("R8", "ignored writes", wr_cnt, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid_i = 1'b0; cmd_pull_i = 1'b0;
    reg_data_i = '0; ptr_i = '0;
    for (int i = 0; i < 256; i++) mem_model[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    t_push_ok();
    t_pull_ok();
    t_push_to_full();
    t_pull_to_empty();
    t_push_trap();
    t_push_mixed_trap();
    t_push_abort_both();
    t_pull_abort_word();
    t_pull_trap_space();
    t_busy_ignore();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule